// File: doc/BRIEF.md
# Legacy Video Register and RAM Snooper

This block sits on the host write bus beside an older on-board video controller. It watches every host write and copies the ones that matter into a newer graphics subsystem. The old controller still receives the same writes, so it keeps running on its own video clock. The block itself forwards nothing to the old controller.

Three kinds of write are copied:

- Writes that land in the low system-RAM window are queued and replayed into a fixed mirror window of graphics memory.
- Writes to the old 256-colour palette are captured into a local palette, which a pixel stage can read.
- Writes to the old video timing registers are latched, and a pulse tells a later translation stage to recompute.

One legacy register carries a spare bit that the block redefines. On a read, that bit reports whether an extended resolution is active. When old software saves the registers and later restores them, the bit is restored too. A rewrite with the bit set then raises a restore pulse instead of a recompute pulse, so the extended mode comes back.

Top module: `legacy_snoop`

## Requirements
- R1: After reset, `hw_ready` is 1, `gm_valid` is 0, `tmg_upd` and `ext_restore` are 0, and every timing register reads 0.
- R2: An accepted write with `hw_addr` below 2^MIRROR_AW is presented on the graphics port with address MIRROR_BASE + `hw_addr` and with the same data and byte enables. Such writes appear in acceptance order, and a presented write holds stable until `gm_ready` is seen.
- R3: An accepted write at or above 2^MIRROR_AW that is outside the palette and timing windows produces no graphics write.
- R4: When the mirror queue holds FIFO_DEPTH entries, `hw_ready` is 0 while a RAM-window write is presented. `hw_ready` stays 1 for writes to any other address. No mirrored write is lost.
- R5: A write to PAL_BASE + 4*i updates palette entry i. Only bytes whose `hw_be` bit is set change: bit 0 enables data bits 7:0, bit 1 enables 15:8, and so on. `pal_rdata` shows entry `pal_raddr` one clock after the address is sampled.
- R6: A write to TREG_BASE + 2*k, for k < NUM_TREG, latches `hw_wdata[15:0]` into timing register k under `hw_be[1:0]`. Register k appears on `tmg_regs[16k+15:16k]` in the cycle after acceptance.
- R7: `tmg_upd` is high for exactly the one cycle after an accepted timing-register write, except for the case in R10.
- R8: A read of FLAG_ADDR is claimed (`hr_claim`=1). In `hr_rdata[15:0]`, bit FLAG_BIT equals `ext_active`, and the other bits equal the stored flag register. Bits 31:16 are 0.
- R9: A read of any other address is not claimed, and `hr_rdata` is 0.
- R10: A write to FLAG_ADDR with `hw_wdata[FLAG_BIT]`=1 raises `ext_restore` for one cycle and leaves `tmg_upd` low. With that bit 0, the write raises `tmg_upd` and not `ext_restore`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_valid | input | 1 | Host write present |
| hw_addr | input | 32 | Host write byte address |
| hw_wdata | input | 32 | Host write data |
| hw_be | input | 4 | Host write byte enables |
| hw_ready | output | 1 | Host write may complete; low stalls the bus |
| hr_valid | input | 1 | Host read present |
| hr_addr | input | 32 | Host read byte address |
| hr_claim | output | 1 | Block answers this read |
| hr_rdata | output | 32 | Read data for a claimed read |
| ext_active | input | 1 | Extended resolution currently active |
| gm_valid | output | 1 | Graphics memory write present |
| gm_ready | input | 1 | Graphics memory accepts the write |
| gm_addr | output | 32 | Graphics memory byte address |
| gm_data | output | 32 | Graphics memory write data |
| gm_be | output | 4 | Graphics memory byte enables |
| pal_raddr | input | 8 | Local palette read index |
| pal_rdata | output | 32 | Local palette entry, one cycle later |
| tmg_regs | output | NUM_TREG*16 | Latched timing registers, register k at bits 16k+15:16k |
| tmg_upd | output | 1 | Timing register changed; recompute |
| ext_restore | output | 1 | Restore the saved extended mode |

## Verification
The bench builds the block with MIRROR_AW=12 and FIFO_DEPTH=2. The other parameters keep their defaults.

The 4 KB window lets the bench hit both edges of the mirror range cheaply: the last word inside it, and the first address past it. The two-entry queue fills after only two writes while graphics memory is held off, so the stall and the later in-order drain show up within a few cycles.

// File: rtl/snoop_pkg.sv
// Package: shared types for the legacy snooper.
// Assumes a 32-bit host bus with four byte lanes.
package snoop_pkg;

    // One queued mirror write towards graphics memory.
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } mirror_wr_t;

    // Destination class of a host address.
    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RAM  = 2'd1,
        DST_PAL  = 2'd2,
        DST_TMG  = 2'd3
    } snoop_dst_e;

endpackage

// File: rtl/snoop_decode.sv
// Module: snoop_decode
// Classifies a host byte address into RAM window, palette window,
// timing window or none, and extracts the entry index.
// Assumes the three windows do not overlap.
module snoop_decode
    import snoop_pkg::*;
#(
    parameter int          MIRROR_AW   = 24,
    parameter logic [31:0] PAL_BASE    = 32'hFFFF_9800,
    parameter int          PAL_ENTRIES = 256,
    parameter logic [31:0] TREG_BASE   = 32'hFFFF_8280,
    parameter int          NUM_TREG    = 34,
    localparam int         PIW         = $clog2(PAL_ENTRIES),
    localparam int         TIW         = $clog2(NUM_TREG)
) (
    input  logic [31:0]    addr,
    output snoop_dst_e     dst,
    output logic [PIW-1:0] pal_idx,
    output logic [TIW-1:0] treg_idx
);

    localparam logic [31:0] PAL_END  = PAL_BASE + 32'(4 * PAL_ENTRIES);
    localparam logic [31:0] TREG_END = TREG_BASE + 32'(2 * NUM_TREG);

    logic [31:0] pal_off;
    logic [31:0] treg_off;

    // Offsets into the palette and timing windows.
    assign pal_off  = addr - PAL_BASE;
    assign treg_off = addr - TREG_BASE;
    assign pal_idx  = pal_off[PIW+1:2];
    assign treg_idx = treg_off[TIW:1];

    // Window classification.
    always_comb begin
        if (addr[31:MIRROR_AW] == '0)
            dst = DST_RAM;
        else if (addr >= PAL_BASE && addr < PAL_END)
            dst = DST_PAL;
        else if (addr >= TREG_BASE && addr < TREG_END)
            dst = DST_TMG;
        else
            dst = DST_NONE;
    end

endmodule

// File: rtl/snoop_fifo.sv
// Module: snoop_fifo
// Small synchronous FIFO for mirror writes.
// The producer must not push while full. Pop happens when the consumer
// takes the head (valid and ready).
module snoop_fifo #(
    parameter int WIDTH = 68,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign head  = slots[rd_ptr];

    // Storage write; no reset needed for data.
    always_ff @(posedge clk) begin
        if (push)
            slots[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/snoop_palette.sv
// Module: snoop_palette
// Local copy of the legacy palette, written per byte lane.
// Has a registered read port for the pixel stage.
// Entries are not reset; software rewrites the palette at boot.
module snoop_palette #(
    parameter int ENTRIES = 256,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [3:0]    wbe,
    input  logic [IW-1:0] ridx,
    output logic [31:0]   rdata
);

    logic [31:0] entries [ENTRIES];

    // One lane writer per byte.
    for (genvar b = 0; b < 4; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && wbe[b])
                entries[widx][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    // Registered read for the pixel stage.
    always_ff @(posedge clk) begin
        rdata <= entries[ridx];
    end

endmodule

// File: rtl/snoop_tregs.sv
// Module: snoop_tregs
// Latches the legacy 16-bit timing registers.
// Raises an update pulse after each write. A write to the flag register
// with the flag bit set raises a restore pulse instead.
module snoop_tregs #(
    parameter int NUM_TREG = 34,
    parameter int FLAG_IDX = 32,
    parameter int FLAG_BIT = 8,
    localparam int TIW     = $clog2(NUM_TREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [TIW-1:0]        widx,
    input  logic [15:0]           wdata,
    input  logic [1:0]            wbe,
    output logic [NUM_TREG*16-1:0] regs_flat,
    output logic [15:0]           flag_reg,
    output logic                  upd,
    output logic                  restore
);

    logic [15:0] regs [NUM_TREG];
    logic        hit_flag;

    assign hit_flag = we && (widx == TIW'(FLAG_IDX)) && wdata[FLAG_BIT];

    // One register slice per timing register.
    for (genvar k = 0; k < NUM_TREG; k++) begin : g_reg
        // Byte-lane write of register k.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (we && widx == TIW'(k)) begin
                if (wbe[0]) regs[k][7:0]  <= wdata[7:0];
                if (wbe[1]) regs[k][15:8] <= wdata[15:8];
            end
        end
        assign regs_flat[k*16 +: 16] = regs[k];
    end

    assign flag_reg = regs[FLAG_IDX];

    // Recompute / restore pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd     <= 1'b0;
            restore <= 1'b0;
        end else begin
            upd     <= we && !hit_flag;
            restore <= hit_flag;
        end
    end

endmodule

// File: rtl/legacy_snoop.sv
// Module: legacy_snoop (top)
// Snoops host writes bound for the legacy video controller and system
// RAM. It mirrors RAM writes into graphics memory, captures the palette,
// latches the timing registers and answers reads of the flag register.
// Assumes MIRROR_BASE is aligned to 2^MIRROR_AW and that the host holds
// a write until hw_ready is seen high.
module legacy_snoop
    import snoop_pkg::*;
#(
    parameter int          MIRROR_AW   = 24,
    parameter logic [31:0] MIRROR_BASE = 32'hA000_0000,
    parameter int          FIFO_DEPTH  = 4,
    parameter logic [31:0] PAL_BASE    = 32'hFFFF_9800,
    parameter int          PAL_ENTRIES = 256,
    parameter logic [31:0] TREG_BASE   = 32'hFFFF_8280,
    parameter int          NUM_TREG    = 34,
    parameter logic [31:0] FLAG_ADDR   = 32'hFFFF_82C0,
    parameter int          FLAG_BIT    = 8,
    localparam int         PIW         = $clog2(PAL_ENTRIES),
    localparam int         TIW         = $clog2(NUM_TREG),
    localparam int         FLAG_IDX    = int'((FLAG_ADDR - TREG_BASE) >> 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_valid,
    input  logic [31:0]            hw_addr,
    input  logic [31:0]            hw_wdata,
    input  logic [3:0]             hw_be,
    output logic                   hw_ready,
    input  logic                   hr_valid,
    input  logic [31:0]            hr_addr,
    output logic                   hr_claim,
    output logic [31:0]            hr_rdata,
    input  logic                   ext_active,
    output logic                   gm_valid,
    input  logic                   gm_ready,
    output logic [31:0]            gm_addr,
    output logic [31:0]            gm_data,
    output logic [3:0]             gm_be,
    input  logic [PIW-1:0]         pal_raddr,
    output logic [31:0]            pal_rdata,
    output logic [NUM_TREG*16-1:0] tmg_regs,
    output logic                   tmg_upd,
    output logic                   ext_restore
);

    snoop_dst_e     dst;
    logic [PIW-1:0] pal_idx;
    logic [TIW-1:0] treg_idx;
    logic           accept;
    logic           fifo_full;
    logic           fifo_empty;
    mirror_wr_t     push_item;
    mirror_wr_t     head_item;
    logic [15:0]    flag_reg;
    logic [15:0]    flag_view;

    snoop_decode #(
        .MIRROR_AW  (MIRROR_AW),
        .PAL_BASE   (PAL_BASE),
        .PAL_ENTRIES(PAL_ENTRIES),
        .TREG_BASE  (TREG_BASE),
        .NUM_TREG   (NUM_TREG)
    ) u_dec (
        .addr    (hw_addr),
        .dst     (dst),
        .pal_idx (pal_idx),
        .treg_idx(treg_idx)
    );

    // Stall only RAM writes, and only when the queue has no room.
    assign hw_ready = !(hw_valid && dst == DST_RAM && fifo_full);
    assign accept   = hw_valid && hw_ready;

    // Mirror item: same offset moved into the graphics window.
    assign push_item = '{addr: MIRROR_BASE + hw_addr, data: hw_wdata, be: hw_be};

    snoop_fifo #(
        .WIDTH($bits(mirror_wr_t)),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept && dst == DST_RAM),
        .push_data(push_item),
        .pop      (gm_valid && gm_ready),
        .head     (head_item),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    assign gm_valid = !fifo_empty;
    assign gm_addr  = head_item.addr;
    assign gm_data  = head_item.data;
    assign gm_be    = head_item.be;

    snoop_palette #(
        .ENTRIES(PAL_ENTRIES)
    ) u_pal (
        .clk  (clk),
        .we   (accept && dst == DST_PAL),
        .widx (pal_idx),
        .wdata(hw_wdata),
        .wbe  (hw_be),
        .ridx (pal_raddr),
        .rdata(pal_rdata)
    );

    snoop_tregs #(
        .NUM_TREG(NUM_TREG),
        .FLAG_IDX(FLAG_IDX),
        .FLAG_BIT(FLAG_BIT)
    ) u_treg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (accept && dst == DST_TMG),
        .widx     (treg_idx),
        .wdata    (hw_wdata[15:0]),
        .wbe      (hw_be[1:0]),
        .regs_flat(tmg_regs),
        .flag_reg (flag_reg),
        .upd      (tmg_upd),
        .restore  (ext_restore)
    );

    // Flag register view: the stored bits with the mode bit live.
    always_comb begin
        flag_view           = flag_reg;
        flag_view[FLAG_BIT] = ext_active;
    end

    // Read answer: only the flag register is claimed.
    always_comb begin
        hr_claim = hr_valid && (hr_addr == FLAG_ADDR);
        hr_rdata = hr_claim ? {16'h0000, flag_view} : 32'h0;
    end

endmodule

// File: rtl/legacy_snoop_chk.sv
// Module: legacy_snoop_chk
// Port-level properties of legacy_snoop, attached by bind.
module legacy_snoop_chk #(
    parameter int          MIRROR_AW   = 24,
    parameter logic [31:0] MIRROR_BASE = 32'hA000_0000,
    parameter logic [31:0] FLAG_ADDR   = 32'hFFFF_82C0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_valid,
    input logic        hw_ready,
    input logic [31:0] hr_addr,
    input logic        hr_claim,
    input logic [31:0] hr_rdata,
    input logic        gm_valid,
    input logic        gm_ready,
    input logic [31:0] gm_addr,
    input logic [31:0] gm_data,
    input logic [3:0]  gm_be,
    input logic        tmg_upd,
    input logic        ext_restore
);

    // A stalled graphics write must hold still.
    AST_GM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        gm_valid && !gm_ready |=> gm_valid && $stable(gm_addr) && $stable(gm_data) && $stable(gm_be)); // R2

    // Graphics writes stay inside the mirror window.
    AST_MIRROR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        gm_valid |-> gm_addr[31:MIRROR_AW] == MIRROR_BASE[31:MIRROR_AW]); // R3

    // The host is stalled only while it presents a write.
    AST_STALL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_ready |-> hw_valid); // R4

    // The recompute pulse follows an accepted write.
    AST_UPD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tmg_upd |-> $past(hw_valid && hw_ready)); // R7

    // Only the flag register is ever claimed.
    AST_CLAIM_FLAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        hr_claim |-> hr_addr == FLAG_ADDR); // R9

    // Unclaimed reads return zero.
    AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hr_claim |-> hr_rdata == 32'h0); // R9

    // Restore and recompute never fire together.
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmg_upd && ext_restore)); // R10

endmodule

bind legacy_snoop legacy_snoop_chk #(
    .MIRROR_AW  (MIRROR_AW),
    .MIRROR_BASE(MIRROR_BASE),
    .FLAG_ADDR  (FLAG_ADDR)
) u_chk (.*);

// File: tb/legacy_snoop_test.sv
`timescale 1ns/1ps
module legacy_snoop_test;

    localparam int          MAW   = 12;
    localparam logic [31:0] MBASE = 32'hA000_0000;
    localparam logic [31:0] PBASE = 32'hFFFF_9800;
    localparam logic [31:0] TBASE = 32'hFFFF_8280;
    localparam logic [31:0] FADDR = 32'hFFFF_82C0;
    localparam int          NTR   = 34;
    localparam int          FBIT  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_valid = 1'b0;
    logic [31:0] hw_addr = '0;
    logic [31:0] hw_wdata = '0;
    logic [3:0]  hw_be = '0;
    logic        hw_ready;
    logic        hr_valid = 1'b0;
    logic [31:0] hr_addr = '0;
    logic        hr_claim;
    logic [31:0] hr_rdata;
    logic        ext_active = 1'b0;
    logic        gm_valid;
    logic        gm_ready = 1'b1;
    logic [31:0] gm_addr;
    logic [31:0] gm_data;
    logic [3:0]  gm_be;
    logic [7:0]  pal_raddr = '0;
    logic [31:0] pal_rdata;
    logic [NTR*16-1:0] tmg_regs;
    logic        tmg_upd;
    logic        ext_restore;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [67:0] exp_q [$];

    always #4 clk = ~clk;

    legacy_snoop #(.MIRROR_AW(MAW), .FIFO_DEPTH(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .hw_valid(hw_valid), .hw_addr(hw_addr), .hw_wdata(hw_wdata), .hw_be(hw_be),
        .hw_ready(hw_ready),
        .hr_valid(hr_valid), .hr_addr(hr_addr), .hr_claim(hr_claim), .hr_rdata(hr_rdata),
        .ext_active(ext_active),
        .gm_valid(gm_valid), .gm_ready(gm_ready), .gm_addr(gm_addr), .gm_data(gm_data),
        .gm_be(gm_be),
        .pal_raddr(pal_raddr), .pal_rdata(pal_rdata),
        .tmg_regs(tmg_regs), .tmg_upd(tmg_upd), .ext_restore(ext_restore)
    );

    task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present a write, wait for ready, record expected mirror.
    task automatic hw_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        hw_addr = a; hw_wdata = d; hw_be = be; hw_valid = 1'b1;
        #1;
        while (!hw_ready) begin
            @(negedge clk);
            #1;
        end
        if (a < (32'd1 << MAW))
            exp_q.push_back({MBASE + a, d, be});
        @(posedge clk);
        #1;
        hw_valid = 1'b0;
    endtask

    // Monitor: compare each accepted graphics write with the queue (R2, R3).
    always @(negedge clk) begin
        if (rst_n && gm_valid && gm_ready) begin
            if (exp_q.size() == 0)
                check("R3 unexpected mirror write", {gm_addr, gm_data, gm_be}, 68'h0);
            else
                check("R2 mirror write", {gm_addr, gm_data, gm_be}, exp_q.pop_front());
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 hw_ready", hw_ready, 1);
        check("R1 gm_valid", gm_valid, 0);
        check("R1 tmg_upd", tmg_upd, 0);
        check("R1 ext_restore", ext_restore, 0);
        check("R1 tmg_regs", tmg_regs[63:0], 0);

        // R2 mirrored writes with differing byte enables, including the top word
        hw_write(32'h0000_0010, 32'h1122_3344, 4'b1111);
        hw_write(32'h0000_0020, 32'h0000_BEEF, 4'b0011);
        hw_write(32'h0000_0FFC, 32'hCAFE_0000, 4'b1000);
        repeat (4) @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);

        // R3 writes past the mirror window are not mirrored
        hw_write(32'h0000_1000, 32'hDEAD_0001, 4'b1111);
        hw_write(32'h0002_0000, 32'hDEAD_0002, 4'b1111);
        repeat (3) @(negedge clk);
        check("R3 no graphics write", gm_valid, 0);

        // R4 full queue stalls RAM writes, not others
        gm_ready = 1'b0;
        hw_write(32'h0000_0100, 32'hA1A1_A1A1, 4'b1111);
        hw_write(32'h0000_0104, 32'hB2B2_B2B2, 4'b1111);
        @(negedge clk);
        hw_addr = 32'h0000_0108; hw_wdata = 32'hC3C3_C3C3; hw_be = 4'hF; hw_valid = 1'b1;
        #1;
        check("R4 stall when full", hw_ready, 0);
        hw_addr = PBASE;
        #1;
        check("R4 non-RAM not stalled", hw_ready, 1);
        hw_valid = 1'b0;
        @(negedge clk);
        gm_ready = 1'b1;
        hw_write(32'h0000_0108, 32'hC3C3_C3C3, 4'b1111);
        repeat (5) @(negedge clk);
        check("R4 all mirrored in order", exp_q.size(), 0);

        // R5 palette capture with byte enables
        hw_write(PBASE + 32'd20, 32'h8899_AABB, 4'b1111);
        hw_write(PBASE + 32'd20, 32'h0000_5500, 4'b0010);
        hw_write(PBASE + 32'd1020, 32'h0102_0304, 4'b1111);
        @(negedge clk) pal_raddr = 8'd5;
        @(negedge clk);
        check("R5 palette entry 5", pal_rdata, 32'h8899_55BB);
        pal_raddr = 8'd255;
        @(negedge clk);
        check("R5 palette entry 255", pal_rdata, 32'h0102_0304);

        // R6 / R7 timing register latch and pulse
        hw_write(TBASE + 32'd2, 32'hFFFF_1234, 4'b1111);
        @(negedge clk);
        check("R6 treg1 value", tmg_regs[31:16], 16'h1234);
        check("R7 upd pulse", tmg_upd, 1);
        @(negedge clk);
        check("R7 upd one cycle", tmg_upd, 0);
        hw_write(TBASE + 32'd2, 32'h0000_00AB, 4'b0001);
        @(negedge clk);
        check("R6 treg1 byte write", tmg_regs[31:16], 16'h12AB);
        hw_write(TBASE + 32'd66, 32'h0000_7E7E, 4'b0011);
        @(negedge clk);
        check("R6 last treg", tmg_regs[NTR*16-1 -: 16], 16'h7E7E);

        // R10 flag write with bit clear: recompute, no restore
        hw_write(FADDR, 32'h0000_0055, 4'b0011);
        @(negedge clk);
        check("R10 clear-bit upd", tmg_upd, 1);
        check("R10 clear-bit no restore", ext_restore, 0);

        // R8 flag readback follows ext_active
        ext_active = 1'b1;
        hr_valid = 1'b1; hr_addr = FADDR;
        #1;
        check("R8 claim", hr_claim, 1);
        check("R8 data active", hr_rdata, 32'h0000_0155);
        ext_active = 1'b0;
        #1;
        check("R8 data legacy", hr_rdata, 32'h0000_0055);

        // R9 other addresses are left alone
        hr_addr = TBASE + 32'd2;
        #1;
        check("R9 no claim", hr_claim, 0);
        check("R9 zero data", hr_rdata, 0);
        hr_valid = 1'b0;

        // R10 restore of saved value with bit set
        hw_write(FADDR, 32'h0000_0155, 4'b0011);
        @(negedge clk);
        check("R10 restore pulse", ext_restore, 1);
        check("R10 no upd", tmg_upd, 0);
        @(negedge clk);
        check("R10 restore one cycle", ext_restore, 0);

        check("R2 final queue empty", exp_q.size(), 0);
        finish_run();
    end

endmodule